// File: doc/BRIEF.md
# Reset Cause and Sleep Controller

This block sequences a small microcontroller core through its restart events: power-on, an external master clear, a watchdog overflow and a wake-up from sleep caused by a port pin change. Each restart holds the core in reset for an oscillator start-up delay, then pulses a reset-vector request as the core reset releases.

Three flags tell firmware why the core restarted: a wake flag, a timeout flag and a power-down flag. Each restart cause writes them according to whether the core was asleep when the cause arrived. The instruction decoder also drives two strobes. The sleep strobe stops the oscillator and takes a snapshot of the watched port pins. The watchdog-clear strobe marks a normal running state.

The delay is counted in ticks of a free-running reference. A power-on delay is the selected long value. A later restart uses the same long value with a crystal clock, and a fixed short value with an RC clock.

Top module: `rstc_sleep_ctrl`

## Requirements
- R1: While `rst_ni` is low and before the first clock edge after its release: wake=0, timeout=1, power-down=1, `core_rst_o`=1, `osc_stop_o`=0.
- R2: After power-on, `core_rst_o` stays high for BASE_TICKS<<k ticks. k is 0, 1 or 2 for `dly_sel_i` = 0, 1 or 2, and `dly_sel_i`=3 acts as 2.
- R3: After a master clear, watchdog or pin-wake restart, the delay is BASE_TICKS<<k ticks when `osc_rc_i`=0 and SHORT_TICKS ticks when `osc_rc_i`=1.
- R4: The delay counter advances only on cycles with `tick_i`=1. `vec_req_o` is high for exactly the one cycle in which `core_rst_o` first reads low after a restart.
- R5: `mclr_ni` low outside sleep clears the wake flag, leaves timeout and power-down unchanged, and restarts the core.
- R6: `mclr_ni` low during sleep sets wake=0, timeout=1, power-down=0, and ends sleep.
- R7: A `wdt_ovf_i` pulse outside sleep sets wake=0, timeout=0, power-down=1, and restarts the core.
- R8: A `wdt_ovf_i` pulse during sleep clears all three flags, ends sleep and restarts the core.
- R9: During sleep with `wake_en_ni`=0, a change on `portb_i` bit 0, 1, 3 or 4 relative to the snapshot taken at sleep sets wake=1, timeout=1, power-down=0 and restarts the core. Changes on bits 2 and 5 are ignored. All changes are ignored when `wake_en_ni`=1.
- R10: The sleep strobe sets timeout=1 and power-down=0, keeps the wake flag, and holds `osc_stop_o` high until a wake event.
- R11: The watchdog-clear strobe sets timeout=1 and power-down=1.
- R12: The watchdog overflow, sleep and clear inputs are ignored while `core_rst_o` is high. The sleep and clear strobes are ignored while asleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| mclr_ni | input | 1 | Synchronized master clear, active low |
| wdt_ovf_i | input | 1 | Watchdog overflow pulse |
| sleep_i | input | 1 | Sleep strobe from the decoder |
| wdt_clr_i | input | 1 | Watchdog-clear strobe from the decoder |
| tick_i | input | 1 | Reference tick for start-up counting |
| portb_i | input | PB_W | Synchronized port B pin states |
| wake_en_ni | input | 1 | Pin-change wake enable, active low |
| osc_rc_i | input | 1 | 1 = internal or external RC clock type |
| dly_sel_i | input | 2 | Start-up delay option |
| core_rst_o | output | 1 | Core reset |
| osc_stop_o | output | 1 | Oscillator stop (sleep) |
| vec_req_o | output | 1 | Reset-vector request pulse |
| wake_flag_o | output | 1 | Pin-change wake flag |
| to_flag_o | output | 1 | Watchdog-timeout flag |
| pd_flag_o | output | 1 | Power-down flag |

## Verification
The bench builds the block with BASE_TICKS=4 and SHORT_TICKS=3, so the long delays are 4, 8 and 16 ticks. This lets it sweep every delay option against both clock types, for power-on, watchdog and master-clear restarts, and count each hold exactly. The short values also keep directed cases within reach: a wake on each watched pin, the unwatched pins, wake disabled, stalled ticks, and a watchdog pulse in the middle of a delay.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  typedef enum logic [2:0] {
    EV_NONE,
    EV_MCLR,
    EV_WDT,
    EV_PIN,
    EV_SLEEP,
    EV_CLR
  } ev_e;
endpackage

// File: rtl/rstc_delay.sv
module rstc_delay #(
  parameter int BASE_TICKS  = 20000,
  parameter int SHORT_TICKS = 300
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic       long_i,
  input  logic       rc_i,
  input  logic [1:0] sel_i,
  input  logic       tick_i,
  output logic       busy_o
);
  localparam int LONG_MAX = BASE_TICKS * 4;
  localparam int MAX_LEN  = (LONG_MAX > SHORT_TICKS) ? LONG_MAX : SHORT_TICKS;
  localparam int CW       = $clog2(MAX_LEN + 1);

  logic [CW-1:0] cnt_q, long_len, len;
  logic [1:0]    shamt;

  always_comb begin
    shamt    = (sel_i == 2'd0) ? 2'd0 : (sel_i == 2'd1) ? 2'd1 : 2'd2;
    long_len = CW'(BASE_TICKS) << shamt;
    len      = (long_i || !rc_i) ? long_len : CW'(SHORT_TICKS);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= len;
    else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  p_hold_no_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && !tick_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/rstc_wake_det.sv
module rstc_wake_det #(
  parameter int          PB_W       = 6,
  parameter logic [5:0]  WATCH_MASK = 6'b01_1011
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            capture_i,
  input  logic            asleep_i,
  input  logic            wake_en_ni,
  input  logic [PB_W-1:0] pins_i,
  output logic            wake_o
);
  logic [PB_W-1:0] snap_q, diff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        snap_q <= '0;
    else if (capture_i) snap_q <= pins_i;
  end

  assign diff   = (pins_i ^ snap_q) & PB_W'(WATCH_MASK);
  assign wake_o = asleep_i && !wake_en_ni && (diff != '0);

  p_snap_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (asleep_i && !capture_i) |=> $stable(snap_q));
endmodule

// File: rtl/rstc_flags.sv
module rstc_flags
  import rstc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  ev_e  ev_i,
  input  logic asleep_i,
  output logic wake_o,
  output logic to_o,
  output logic pd_o
);
  logic wake_d, to_d, pd_d;

  always_comb begin
    wake_d = wake_o;
    to_d   = to_o;
    pd_d   = pd_o;
    unique case (ev_i)
      EV_MCLR: begin
        wake_d = 1'b0;
        if (asleep_i) begin to_d = 1'b1; pd_d = 1'b0; end
      end
      EV_WDT: begin
        wake_d = 1'b0; to_d = 1'b0; pd_d = !asleep_i;
      end
      EV_PIN:   begin wake_d = 1'b1; to_d = 1'b1; pd_d = 1'b0; end
      EV_SLEEP: begin to_d = 1'b1; pd_d = 1'b0; end
      EV_CLR:   begin to_d = 1'b1; pd_d = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wake_o <= 1'b0;
      to_o   <= 1'b1;
      pd_o   <= 1'b1;
    end else begin
      wake_o <= wake_d;
      to_o   <= to_d;
      pd_o   <= pd_d;
    end
  end

  p_sleep_flags_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i == EV_SLEEP) |=> (to_o && !pd_o));
  p_pin_flags_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i == EV_PIN) |=> (wake_o && to_o && !pd_o));
  p_wdt_sleep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i == EV_WDT && asleep_i) |=> (!wake_o && !to_o && !pd_o));
endmodule

// File: rtl/rstc_sleep_ctrl.sv
module rstc_sleep_ctrl
  import rstc_pkg::*;
#(
  parameter int BASE_TICKS  = 20000,
  parameter int SHORT_TICKS = 300,
  parameter int PB_W        = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            mclr_ni,
  input  logic            wdt_ovf_i,
  input  logic            sleep_i,
  input  logic            wdt_clr_i,
  input  logic            tick_i,
  input  logic [PB_W-1:0] portb_i,
  input  logic            wake_en_ni,
  input  logic            osc_rc_i,
  input  logic [1:0]      dly_sel_i,
  output logic            core_rst_o,
  output logic            osc_stop_o,
  output logic            vec_req_o,
  output logic            wake_flag_o,
  output logic            to_flag_o,
  output logic            pd_flag_o
);
  logic por_pend_q, asleep_q, core_rst_q, busy, pin_wake, load;
  ev_e  ev;

  // priority: master clear, then reset hold, then wdt, then pin/sleep/clear
  always_comb begin
    ev = EV_NONE;
    if (!mclr_ni)                 ev = EV_MCLR;
    else if (core_rst_o)          ev = EV_NONE;
    else if (wdt_ovf_i)           ev = EV_WDT;
    else if (asleep_q && pin_wake) ev = EV_PIN;
    else if (!asleep_q && sleep_i) ev = EV_SLEEP;
    else if (!asleep_q && wdt_clr_i) ev = EV_CLR;
  end

  assign load       = por_pend_q || ev == EV_MCLR || ev == EV_WDT || ev == EV_PIN;
  assign core_rst_o = por_pend_q || busy;
  assign osc_stop_o = asleep_q;
  assign vec_req_o  = core_rst_q && !core_rst_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      por_pend_q <= 1'b1;
      asleep_q   <= 1'b0;
      core_rst_q <= 1'b1;
    end else begin
      por_pend_q <= 1'b0;
      core_rst_q <= core_rst_o;
      if (ev == EV_SLEEP)  asleep_q <= 1'b1;
      else if (load)       asleep_q <= 1'b0;
    end
  end

  rstc_delay #(.BASE_TICKS(BASE_TICKS), .SHORT_TICKS(SHORT_TICKS)) u_delay (
    .clk_i, .rst_ni,
    .load_i (load),
    .long_i (por_pend_q),
    .rc_i   (osc_rc_i),
    .sel_i  (dly_sel_i),
    .tick_i,
    .busy_o (busy)
  );

  rstc_wake_det #(.PB_W(PB_W)) u_wake (
    .clk_i, .rst_ni,
    .capture_i  (ev == EV_SLEEP),
    .asleep_i   (asleep_q),
    .wake_en_ni,
    .pins_i     (portb_i),
    .wake_o     (pin_wake)
  );

  rstc_flags u_flags (
    .clk_i, .rst_ni,
    .ev_i     (ev),
    .asleep_i (asleep_q),
    .wake_o   (wake_flag_o),
    .to_o     (to_flag_o),
    .pd_o     (pd_flag_o)
  );

  p_stop_not_rst_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_stop_o |-> !core_rst_o);
  p_vec_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_req_o |=> !vec_req_o);
  p_vec_at_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_req_o |-> (!core_rst_o && $past(core_rst_o)));
endmodule

// File: tb/rstc_sleep_ctrl_test.sv
module rstc_sleep_ctrl_test;
  localparam int BASE = 4;
  localparam int SHORT = 3;

  logic clk = 0, rst_ni = 0, mclr_ni = 1, wdt_ovf = 0, sleep = 0, wclr = 0, tick = 1;
  logic [5:0] pb = 6'b10_0101;
  logic wake_en_ni = 0, osc_rc = 0;
  logic [1:0] sel = 0;
  logic core_rst, osc_stop, vec_req, wf, tf, pf;
  int errors = 0, checks = 0, n;

  always #4 clk = ~clk;

  rstc_sleep_ctrl #(.BASE_TICKS(BASE), .SHORT_TICKS(SHORT), .PB_W(6)) uut (
    .clk_i(clk), .rst_ni, .mclr_ni, .wdt_ovf_i(wdt_ovf), .sleep_i(sleep),
    .wdt_clr_i(wclr), .tick_i(tick), .portb_i(pb), .wake_en_ni,
    .osc_rc_i(osc_rc), .dly_sel_i(sel), .core_rst_o(core_rst),
    .osc_stop_o(osc_stop), .vec_req_o(vec_req), .wake_flag_o(wf),
    .to_flag_o(tf), .pd_flag_o(pf));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_flags(input string req, input logic [2:0] exp);
    chk({wf, tf, pf} == exp, req, {wf, tf, pf}, exp);
  endtask

  function automatic int long_len(input logic [1:0] s);
    return BASE << ((s == 0) ? 0 : (s == 1) ? 1 : 2);
  endfunction

  // count samples with core reset high, then check the vector pulse at release
  task automatic count_rst(input string req, input int exp);
    n = 0;
    while (core_rst && n < 1000) begin n++; @(negedge clk); end
    chk(n == exp, req, n, exp);
    chk(vec_req == 1'b1, "R4 vec", vec_req, 1);
    @(negedge clk);
    chk(vec_req == 1'b0, "R4 vec single", vec_req, 0);
  endtask

  task automatic do_por();
    @(negedge clk); rst_ni = 0;
    @(negedge clk);
    chk_flags("R1 flags", 3'b011);
    chk(core_rst && !osc_stop, "R1 rst/stop", {core_rst, osc_stop}, 2'b10);
    rst_ni = 1;
    @(negedge clk);
  endtask

  task automatic pulse(ref logic s, input logic v);
    s = v; @(negedge clk); s = ~v;
  endtask

  task automatic sleep_now();
    pulse(sleep, 1'b1); @(negedge clk);
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int s = 0; s < 4; s++) begin
      for (int r = 0; r < 2; r++) begin
        sel = 2'(s); osc_rc = r[0];
        do_por();
        count_rst("R2 por delay", long_len(sel));
        pulse(wdt_ovf, 1'b1);
        count_rst("R3 wdt delay", osc_rc ? SHORT : long_len(sel));
        chk_flags("R7 wdt awake", 3'b001);
        pulse(mclr_ni, 1'b0);
        count_rst("R3 mclr delay", osc_rc ? SHORT : long_len(sel));
        chk_flags("R5 mclr keeps to/pd", 3'b001);
      end
    end

    sel = 2; osc_rc = 0;
    // R7 R12: watchdog in the middle of a delay must not restart it
    pulse(mclr_ni, 1'b0);
    repeat (5) @(negedge clk);
    pulse(wdt_ovf, 1'b1);
    count_rst("R12 wdt ignored in reset", 16 - 6);
    chk_flags("R12 flags unchanged", 3'b001);

    // R4: no ticks, no progress
    tick = 0;
    pulse(wdt_ovf, 1'b1);
    repeat (30) @(negedge clk);
    chk(core_rst == 1'b1, "R4 hold without tick", core_rst, 1);
    tick = 1;
    count_rst("R4 resume after tick", 16);

    sel = 0; osc_rc = 1;
    pulse(wclr, 1'b1); @(negedge clk);
    chk_flags("R11 clear strobe", 3'b011);
    sleep_now();
    chk_flags("R10 sleep flags", 3'b010);
    chk(osc_stop == 1'b1, "R10 osc stop", osc_stop, 1);
    pulse(wclr, 1'b1); @(negedge clk);
    chk_flags("R12 clear ignored asleep", 3'b010);
    pb[2] = ~pb[2]; repeat (3) @(negedge clk);
    chk(osc_stop && !core_rst, "R9 bit2 ignored", osc_stop, 1);
    pb[5] = ~pb[5]; repeat (3) @(negedge clk);
    chk(osc_stop && !core_rst, "R9 bit5 ignored", osc_stop, 1);
    wake_en_ni = 1; pb[0] = ~pb[0]; repeat (3) @(negedge clk);
    chk(osc_stop && !core_rst, "R9 disabled ignored", osc_stop, 1);
    pb[0] = ~pb[0]; wake_en_ni = 0; repeat (3) @(negedge clk);
    chk(osc_stop == 1'b1, "R9 equal pins no wake", osc_stop, 1);
    pb[3] = ~pb[3]; @(negedge clk);
    chk(osc_stop == 1'b0, "R9 wake ends sleep", osc_stop, 0);
    count_rst("R3 pin wake short delay", SHORT);
    chk_flags("R9 pin wake flags", 3'b110);

    foreach (pb[b]) begin
      if (b == 0 || b == 1 || b == 3 || b == 4) begin
        pulse(wclr, 1'b1); @(negedge clk);
        sleep_now();
        pb[b] = ~pb[b]; @(negedge clk);
        count_rst("R9 watched bit delay", SHORT);
        chk_flags("R9 watched bit wake", 3'b110);
      end
    end

    pulse(mclr_ni, 1'b0);
    count_rst("R5 mclr delay", SHORT);
    chk_flags("R5 mclr clears wake", 3'b010);

    pulse(wclr, 1'b1); @(negedge clk);
    sleep_now();
    pulse(mclr_ni, 1'b0);
    chk(osc_stop == 1'b0, "R6 mclr ends sleep", osc_stop, 0);
    count_rst("R6 mclr sleep delay", SHORT);
    chk_flags("R6 mclr in sleep", 3'b010);

    sleep_now();
    pulse(wdt_ovf, 1'b1);
    chk(osc_stop == 1'b0, "R8 wdt ends sleep", osc_stop, 0);
    count_rst("R8 wdt sleep delay", SHORT);
    chk_flags("R8 wdt in sleep", 3'b000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule